// File: doc/BRIEF.md
# Six-bit symbol packet recompressor

This block sits between an entropy coder's output and a network packetizer. It takes a stream of 6-bit symbols and groups them into packets of up to 341 symbols (2046 bits). A packet ends at its 341st symbol, or earlier if the input marks a symbol as last. While a packet is being collected, each symbol is compared with a small programmable table of frequent values. At the same time the block adds up the length the packet would have in coded form.

When a packet closes, the block chooses between two forms. The coded form is used only if it is strictly shorter than the raw form. The chosen form is sent out one bit at a time behind a single leading flag bit. In the coded form, a symbol that hits the table becomes a 3-bit word and every other symbol becomes a 7-bit escape word. The result is always decodable without side information.

Both data interfaces use valid/ready. A symbol moves when `in_valid` and `in_ready` are both high on a clock edge. An output bit moves when `out_valid` and `out_ready` are both high. `in_ready` is low from the close of a packet until its last bit has been taken. While `out_ready` is low, the output holds its current bit. Table writes are plain registered strobes that can be issued at any time. They go to a staging copy, and each packet uses the copy that was in force when its first symbol was accepted.

Top module: `srx_recompressor`

## Requirements
- R1: A symbol is accepted when `in_valid` and `in_ready` are both high. A packet closes on the accepted symbol that has `in_last` set or that is the 341st of the packet. `in_ready` is low from the cycle after the close until the packet's final output bit has been accepted.
- R2: Each output packet begins with one flag bit: 1 for the coded form, 0 for the raw form.
- R3: In the coded form, a symbol equal to a valid table entry is sent as bit 0 followed by the 2-bit index of the lowest-indexed matching entry.
- R4: In the coded form, a symbol that matches no valid entry is sent as bit 1 followed by its 6 bits.
- R5: The coded form is used only when its length (3 bits per hit, 7 bits per miss) is strictly less than 6 × (symbols in the packet). Otherwise the flag is 0 and the symbols follow unchanged, so a full raw packet is 2047 bits long.
- R6: Only entries with index below the programmed count take part in matching. A count above 4 acts as 4.
- R7: Entry writes (`tbl_we`, `tbl_idx`, `tbl_sym`) and count writes (`tbl_cnt_we`, `tbl_cnt`) apply to every packet whose first symbol is accepted after the write's clock edge. A packet already in progress keeps the table it started with.
- R8: Every field is sent MSB first. `out_end` is high on the last bit of a packet and on no other bit.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_end` hold their values. No bit is dropped or repeated.
- R10: After reset `in_ready` is 1, `out_valid` is 0, the table count is 0 and all entries are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Block can accept a symbol |
| in_sym | input | 6 | Input symbol |
| in_last | input | 1 | Symbol closes the current packet |
| tbl_we | input | 1 | Write one staging table entry |
| tbl_idx | input | 2 | Entry index for the write |
| tbl_sym | input | 6 | Symbol value for the entry |
| tbl_cnt_we | input | 1 | Write the staging valid-entry count |
| tbl_cnt | input | 3 | Number of valid entries |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream takes the bit |
| out_bit | output | 1 | Serial output bit |
| out_end | output | 1 | Last bit of the packet |

## Verification
The hardest case to reach is a table write that arrives while a packet is only partly collected. The bench sends half a packet, rewrites every entry and the count, and then finishes the packet. It checks that this packet decodes with the old table and that the next one uses the new table. The break-even boundary is reached with short packets closed by `in_last`, sized so that coded and raw lengths are exactly equal (raw expected) or one hit better (coded expected). Full packets are drained under an irregular `out_ready` pattern, and every stalled cycle is checked for a held bit.

// File: rtl/srx_pkg.sv
package srx_pkg;
  // Code word lengths shared by the length accumulator and the serializer.
  function automatic int hit_len(input int idx_w);
    return 1 + idx_w;
  endfunction

  function automatic int miss_len(input int sym_w);
    return 1 + sym_w;
  endfunction
endpackage

// File: rtl/srx_match.sv
module srx_match #(
  parameter int SYM_W = 6,
  parameter int TBL_N = 4,
  parameter int IDX_W = 2,
  parameter int TC_W  = 3
) (
  input  logic [TBL_N*SYM_W-1:0] tab,
  input  logic [TC_W-1:0]        cnt,
  input  logic [SYM_W-1:0]       sym,
  output logic                   hit,
  output logic [IDX_W-1:0]       idx
);
  logic [TBL_N-1:0] eq;

  for (genvar i = 0; i < TBL_N; i++) begin : g_cmp
    assign eq[i] = (cnt > TC_W'(i)) && (tab[i*SYM_W +: SYM_W] == sym);
  end

  // lowest index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = TBL_N - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/srx_code_table.sv
module srx_code_table #(
  parameter int SYM_W = 6,
  parameter int TBL_N = 4,
  parameter int IDX_W = 2,
  parameter int TC_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SYM_W-1:0] wr_sym,
  input  logic             cnt_we,
  input  logic [TC_W-1:0]  cnt_val,
  input  logic             snap,
  input  logic             sel_stage,
  input  logic [SYM_W-1:0] a_sym,
  output logic             a_hit,
  output logic [IDX_W-1:0] a_idx,
  input  logic [SYM_W-1:0] b_sym,
  output logic             b_hit,
  output logic [IDX_W-1:0] b_idx
);
  logic [TBL_N*SYM_W-1:0] stage_tab, act_tab;
  logic [TC_W-1:0]        stage_cnt, act_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_tab <= '0;
      stage_cnt <= '0;
      act_tab   <= '0;
      act_cnt   <= '0;
    end else begin
      for (int i = 0; i < TBL_N; i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) stage_tab[i*SYM_W +: SYM_W] <= wr_sym;
      end
      if (cnt_we) stage_cnt <= cnt_val;
      if (snap) begin
        act_tab <= stage_tab;
        act_cnt <= stage_cnt;
      end
    end
  end

  // R7
  active_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(act_tab) && $stable(act_cnt));

  // Port a serves the collector: the first symbol of a packet sees the staging copy.
  srx_match #(.SYM_W(SYM_W), .TBL_N(TBL_N), .IDX_W(IDX_W), .TC_W(TC_W)) u_match_a (
    .tab (sel_stage ? stage_tab : act_tab),
    .cnt (sel_stage ? stage_cnt : act_cnt),
    .sym (a_sym),
    .hit (a_hit),
    .idx (a_idx)
  );

  srx_match #(.SYM_W(SYM_W), .TBL_N(TBL_N), .IDX_W(IDX_W), .TC_W(TC_W)) u_match_b (
    .tab (act_tab),
    .cnt (act_cnt),
    .sym (b_sym),
    .hit (b_hit),
    .idx (b_idx)
  );
endmodule

// File: rtl/srx_packet_buffer.sv
module srx_packet_buffer #(
  parameter int SYM_W    = 6,
  parameter int PKT_SYMS = 341,
  parameter int CNT_W    = 9,
  parameter int PTR_W    = 9,
  parameter int LEN_W    = 12,
  parameter int HIT_LEN  = 3,
  parameter int MISS_LEN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SYM_W-1:0] wr_sym,
  input  logic             wr_hit,
  input  logic             clear,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [SYM_W-1:0] rd_sym,
  output logic [CNT_W-1:0] count,
  output logic [LEN_W-1:0] comp_len
);
  logic [SYM_W-1:0] mem [PKT_SYMS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[PTR_W'(count)] <= wr_sym;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      comp_len <= '0;
    end else if (clear) begin
      count    <= '0;
      comp_len <= '0;
    end else if (wr_en) begin
      count    <= count + CNT_W'(1);
      comp_len <= comp_len + (wr_hit ? LEN_W'(HIT_LEN) : LEN_W'(MISS_LEN));
    end
  end

  assign rd_sym = mem[rd_idx];

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(PKT_SYMS));
endmodule

// File: rtl/srx_bit_serializer.sv
module srx_bit_serializer #(
  parameter int SYM_W    = 6,
  parameter int IDX_W    = 2,
  parameter int CNT_W    = 9,
  parameter int PTR_W    = 9,
  parameter int HIT_LEN  = 3,
  parameter int MISS_LEN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] n_syms,
  input  logic             compress,
  output logic [PTR_W-1:0] rd_idx,
  input  logic [SYM_W-1:0] rd_sym,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic             out_end,
  output logic             done
);
  localparam int CODE_W = MISS_LEN;
  localparam int LW     = $clog2(CODE_W + 1);

  logic             busy, on_flag, comp_r;
  logic [CNT_W-1:0] n_r;
  logic [PTR_W-1:0] sym_ptr;
  logic [LW-1:0]    bit_ptr, clen, sel;
  logic [CODE_W-1:0] code;
  logic             last_sym, last_bit, fire;

  always_comb begin
    if (!comp_r) begin
      code = CODE_W'(rd_sym);
      clen = LW'(SYM_W);
    end else if (hit) begin
      code = CODE_W'(idx);
      clen = LW'(HIT_LEN);
    end else begin
      code = {1'b1, rd_sym};
      clen = LW'(MISS_LEN);
    end
  end

  assign sel       = clen - LW'(1) - bit_ptr;
  assign last_sym  = (CNT_W'(sym_ptr) == n_r - CNT_W'(1));
  assign last_bit  = (bit_ptr == clen - LW'(1));
  assign out_valid = busy;
  assign out_bit   = on_flag ? comp_r : code[sel];
  assign out_end   = busy && !on_flag && last_sym && last_bit;
  assign fire      = busy && out_ready;
  assign done      = fire && out_end;
  assign rd_idx    = sym_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      on_flag <= 1'b0;
      comp_r  <= 1'b0;
      n_r     <= '0;
      sym_ptr <= '0;
      bit_ptr <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      on_flag <= 1'b1;
      comp_r  <= compress;
      n_r     <= n_syms;
      sym_ptr <= '0;
      bit_ptr <= '0;
    end else if (fire) begin
      if (on_flag) begin
        on_flag <= 1'b0;
      end else if (last_bit) begin
        bit_ptr <= '0;
        if (last_sym) busy <= 1'b0;
        else          sym_ptr <= sym_ptr + PTR_W'(1);
      end else begin
        bit_ptr <= bit_ptr + LW'(1);
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_end));

  // R8
  end_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_end |=> !out_valid);
endmodule

// File: rtl/srx_recompressor.sv
module srx_recompressor #(
  parameter int SYM_W    = 6,
  parameter int PKT_SYMS = 341,
  parameter int TBL_N    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [SYM_W-1:0]         in_sym,
  input  logic                     in_last,
  input  logic                     tbl_we,
  input  logic [$clog2(TBL_N)-1:0] tbl_idx,
  input  logic [SYM_W-1:0]         tbl_sym,
  input  logic                     tbl_cnt_we,
  input  logic [$clog2(TBL_N+1)-1:0] tbl_cnt,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_bit,
  output logic                     out_end
);
  import srx_pkg::*;

  localparam int IDX_W    = $clog2(TBL_N);
  localparam int TC_W     = $clog2(TBL_N + 1);
  localparam int CNT_W    = $clog2(PKT_SYMS + 1);
  localparam int PTR_W    = $clog2(PKT_SYMS);
  localparam int HIT_LEN  = hit_len(IDX_W);
  localparam int MISS_LEN = miss_len(SYM_W);
  localparam int LEN_W    = $clog2(PKT_SYMS * MISS_LEN + 1);

  logic             emit_r, start_r;
  logic             accept, close, ser_done;
  logic             a_hit, b_hit;
  logic [IDX_W-1:0] a_idx, b_idx;
  logic [CNT_W-1:0] buf_count;
  logic [LEN_W-1:0] buf_len, raw_len;
  logic [PTR_W-1:0] rd_idx;
  logic [SYM_W-1:0] rd_sym;
  logic             compress;

  assign in_ready = !emit_r;
  assign accept   = in_valid && in_ready;
  assign close    = accept && (in_last || buf_count == CNT_W'(PKT_SYMS - 1));
  assign raw_len  = LEN_W'(buf_count) * LEN_W'(SYM_W);
  assign compress = buf_len < raw_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit_r  <= 1'b0;
      start_r <= 1'b0;
    end else begin
      start_r <= close;
      if (close)         emit_r <= 1'b1;
      else if (ser_done) emit_r <= 1'b0;
    end
  end

  srx_code_table #(.SYM_W(SYM_W), .TBL_N(TBL_N), .IDX_W(IDX_W), .TC_W(TC_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_we),
    .wr_idx    (tbl_idx),
    .wr_sym    (tbl_sym),
    .cnt_we    (tbl_cnt_we),
    .cnt_val   (tbl_cnt),
    .snap      (accept && buf_count == '0),
    .sel_stage (buf_count == '0),
    .a_sym     (in_sym),
    .a_hit     (a_hit),
    .a_idx     (a_idx),
    .b_sym     (rd_sym),
    .b_hit     (b_hit),
    .b_idx     (b_idx)
  );

  srx_packet_buffer #(.SYM_W(SYM_W), .PKT_SYMS(PKT_SYMS), .CNT_W(CNT_W), .PTR_W(PTR_W),
                      .LEN_W(LEN_W), .HIT_LEN(HIT_LEN), .MISS_LEN(MISS_LEN)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept),
    .wr_sym   (in_sym),
    .wr_hit   (a_hit),
    .clear    (ser_done),
    .rd_idx   (rd_idx),
    .rd_sym   (rd_sym),
    .count    (buf_count),
    .comp_len (buf_len)
  );

  srx_bit_serializer #(.SYM_W(SYM_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .PTR_W(PTR_W),
                       .HIT_LEN(HIT_LEN), .MISS_LEN(MISS_LEN)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_r),
    .n_syms    (buf_count),
    .compress  (compress),
    .rd_idx    (rd_idx),
    .rd_sym    (rd_sym),
    .hit       (b_hit),
    .idx       (b_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .out_end   (out_end),
    .done      (ser_done)
  );

  // R1
  no_accept_while_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R1
  close_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> !in_ready);
endmodule

// File: tb/srx_recompressor_test.sv
module srx_recompressor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [5:0] in_sym = '0;
  logic in_ready;
  logic tbl_we = 1'b0, tbl_cnt_we = 1'b0;
  logic [1:0] tbl_idx = '0;
  logic [5:0] tbl_sym = '0;
  logic [2:0] tbl_cnt = '0;
  logic out_valid, out_bit, out_end;
  logic out_ready = 1'b0;

  int checks = 0, fails = 0;
  logic [5:0] pk [341];
  logic [5:0] tab_m [4];
  int cnt_m = 0;
  bit exp_q[$];
  bit got_q[$];
  logic [7:0] lf = 8'hA5;

  always #2.5 clk = ~clk;

  srx_recompressor uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .in_last(in_last), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_sym(tbl_sym), .tbl_cnt_we(tbl_cnt_we), .tbl_cnt(tbl_cnt),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_end(out_end)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // drives the DUT table only; the model is set separately
  task automatic dut_tbl(input int idx, input logic [5:0] s);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 2'(idx); tbl_sym = s;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic dut_cnt(input int c);
    @(negedge clk);
    tbl_cnt_we = 1'b1; tbl_cnt = 3'(c);
    @(negedge clk);
    tbl_cnt_we = 1'b0;
  endtask

  task automatic set_table(input logic [5:0] a, b, c, d, input int cnt);
    dut_tbl(0, a); dut_tbl(1, b); dut_tbl(2, c); dut_tbl(3, d); dut_cnt(cnt);
    tab_m[0] = a; tab_m[1] = b; tab_m[2] = c; tab_m[3] = d; cnt_m = cnt;
  endtask

  // expected stream from the requirements (R2..R6, R8)
  task automatic build_exp(input int n);
    int clen;
    bit comp;
    bit hit[341];
    int hidx[341];
    clen = 0;
    for (int k = 0; k < n; k++) begin
      hit[k] = 1'b0; hidx[k] = 0;
      for (int i = 3; i >= 0; i--)
        if (i < cnt_m && tab_m[i] == pk[k]) begin hit[k] = 1'b1; hidx[k] = i; end
      clen += hit[k] ? 3 : 7;
    end
    comp = clen < 6 * n;
    exp_q.delete();
    exp_q.push_back(comp);
    for (int k = 0; k < n; k++) begin
      if (!comp) for (int b = 5; b >= 0; b--) exp_q.push_back(pk[k][b]);
      else if (hit[k]) begin
        exp_q.push_back(1'b0);
        exp_q.push_back(hidx[k][1]);
        exp_q.push_back(hidx[k][0]);
      end else begin
        exp_q.push_back(1'b1);
        for (int b = 5; b >= 0; b--) exp_q.push_back(pk[k][b]);
      end
    end
  endtask

  task automatic send(input int from, input int to, input bit last_at_end);
    for (int k = from; k < to; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sym = pk[k]; in_last = last_at_end && (k == to - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // mode 0: always ready, 1: mostly ready, 2: half ready
  task automatic drain(input int mode, input string req);
    bit prev_stall, prev_bit, prev_end, fin;
    int stall_bad, cyc;
    prev_stall = 0; prev_bit = 0; prev_end = 0; stall_bad = 0; cyc = 0; fin = 0;
    got_q.delete();
    while (!fin && cyc < 20000) begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (lf[0] | lf[1]) : lf[0];
      #1;
      if (prev_stall && (!out_valid || out_bit != prev_bit || out_end != prev_end))
        stall_bad++;
      prev_stall = out_valid && !out_ready;
      prev_bit = out_bit; prev_end = out_end;
      if (out_valid && out_ready) begin
        got_q.push_back(out_bit);
        if (out_end) fin = 1;
      end
      cyc++;
    end
    @(negedge clk);
    out_ready = 1'b0;
    // R9
    check(stall_bad == 0, "R9", {req, " held bit under stall"}, stall_bad, 0);
    // R8
    check(got_q.size() == exp_q.size(), "R8", {req, " bits up to out_end"}, got_q.size(), exp_q.size());
    begin
      int mism, first;
      mism = 0; first = -1;
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
        if (got_q[i] != exp_q[i]) begin mism++; if (first < 0) first = i; end
      check(mism == 0, req, "bit mismatches", mism, 0);
    end
    check(got_q.size() > 0 && got_q[0] == exp_q[0], "R2",
          {req, " flag"}, got_q.size() > 0 ? int'(got_q[0]) : -1, int'(exp_q[0]));
  endtask

  task automatic t_reset();
    #1;
    check(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
  endtask

  // R10: zero table -> every symbol misses -> raw
  task automatic t_reset_table();
    for (int k = 0; k < 8; k++) pk[k] = 6'(k);
    cnt_m = 0;
    build_exp(8);
    send(0, 8, 1);
    drain(0, "R10");
  endtask

  task automatic t_all_hits();
    set_table(6'd5, 6'd17, 6'd42, 6'd63, 4);
    for (int k = 0; k < 341; k++) pk[k] = tab_m[k % 4];
    build_exp(341);
    send(0, 341, 0);   // R1: closes at 341 without in_last
    #1;
    check(in_ready == 1'b0, "R1", "in_ready after 341st", in_ready, 0);
    drain(1, "R3");
    check(got_q.size() == 1024, "R5", "coded packet length", got_q.size(), 1024);
    #1;
    check(in_ready == 1'b1, "R1", "in_ready after drain", in_ready, 1);
  endtask

  task automatic t_all_miss();
    for (int k = 0; k < 341; k++) pk[k] = 6'(20 + (k % 20));
    build_exp(341);
    send(0, 341, 0);
    drain(0, "R5");
    check(got_q.size() == 2047, "R5", "raw packet length", got_q.size(), 2047);
  endtask

  task automatic t_mixed();
    for (int k = 0; k < 341; k++) pk[k] = (k % 5 == 0) ? 6'(k % 64) : tab_m[k % 4];
    build_exp(341);
    send(0, 341, 0);
    drain(2, "R4");
  endtask

  task automatic t_threshold();
    // 4 symbols, 1 hit: 3+21 = 24 = raw 24 -> raw
    pk[0] = 6'd5; pk[1] = 6'd1; pk[2] = 6'd2; pk[3] = 6'd3;
    build_exp(4);
    send(0, 4, 1);
    drain(0, "R5");
    check(got_q.size() == 25, "R5", "break-even raw length", got_q.size(), 25);
    // 5 symbols, 2 hits: 6+21 = 27 < 30 -> coded
    pk[0] = 6'd5; pk[1] = 6'd17; pk[2] = 6'd1; pk[3] = 6'd2; pk[4] = 6'd3;
    build_exp(5);
    send(0, 5, 1);
    drain(1, "R5");
    check(got_q.size() == 28 && got_q[0] == 1'b1, "R5", "one-better coded length",
          got_q.size(), 28);
  endtask

  task automatic t_count();
    set_table(6'd5, 6'd17, 6'd42, 6'd63, 2);
    for (int k = 0; k < 12; k++) pk[k] = (k % 3 == 0) ? 6'd42 : (k % 3 == 1) ? 6'd5 : 6'd17;
    build_exp(12);
    send(0, 12, 1);
    drain(0, "R6");
    set_table(6'd5, 6'd17, 6'd42, 6'd63, 7);
    for (int k = 0; k < 12; k++) pk[k] = 6'd63;
    build_exp(12);
    send(0, 12, 1);
    drain(0, "R6");
  endtask

  task automatic t_dup();
    set_table(6'd9, 6'd4, 6'd9, 6'd4, 4);
    for (int k = 0; k < 10; k++) pk[k] = (k % 2) ? 6'd4 : 6'd9;
    build_exp(10);
    send(0, 10, 1);
    drain(0, "R3");
    // 9 -> index 0 (000), 4 -> index 1 (001)
    check(got_q.size() > 6 && got_q[1] == 0 && got_q[2] == 0 && got_q[3] == 0 &&
          got_q[4] == 0 && got_q[5] == 0 && got_q[6] == 1, "R3", "lowest matching index",
          got_q.size() > 6 ? int'(got_q[6]) : -1, 1);
  endtask

  task automatic t_midwrite();
    set_table(6'd10, 6'd11, 6'd12, 6'd13, 4);
    for (int k = 0; k < 40; k++) pk[k] = 6'(10 + (k % 4));
    build_exp(40);             // old table governs this packet
    send(0, 20, 0);
    dut_tbl(0, 6'd30); dut_tbl(1, 6'd31); dut_tbl(2, 6'd32); dut_tbl(3, 6'd33); dut_cnt(1);
    send(20, 40, 1);
    drain(1, "R7");
    tab_m[0] = 6'd30; tab_m[1] = 6'd31; tab_m[2] = 6'd32; tab_m[3] = 6'd33; cnt_m = 1;
    for (int k = 0; k < 40; k++) pk[k] = (k % 2) ? 6'd30 : 6'd31;
    build_exp(40);
    send(0, 40, 1);
    drain(0, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset_table();
    t_all_hits();
    t_all_miss();
    t_mixed();
    t_threshold();
    t_count();
    t_dup();
    t_midwrite();
    summary();
  end
endmodule